// File: doc/BRIEF.md
# Fetch-Switched Pattern Bank Selector

This block turns eight 16-bit pattern-memory bank registers into one bank number for each of the eight 1 KB slots of the 8 KB pattern space. The CPU loads each register one byte at a time, through a low-byte window and a high-byte window, with a 3-bit register index. A 2-bit granularity input picks how the slots are grouped: as one 8 KB window, two 4 KB halves, four 2 KB quarters or eight 1 KB slots. Every slot output is then passed through a size mask and combined with outer bank bits, so the result can be placed inside a larger memory.

In 4 KB mode, the CPU does not choose the register for each half directly. Each half has a one-bit latch that picks one of a pair of registers: registers 0/2 for the lower half and 4/6 for the upper half. The latch flips when the video side reads certain tile rows in the pattern space. This lets a picture switch banks partway through rendering with no CPU action. A latch-enable input turns the feature off. While it is off, the halves stay fixed on registers 0 and 4.

Top module: `chr_latch_bank`

## Requirements
- R1: After reset, all sixteen bank bytes are 0xFF. Both latches select the first register of their pair: register 0 for the lower half and register 4 for the upper half.
- R2: A clocked write with `cpu_wr`=1 stores `cpu_data` into register `cpu_idx`. The byte goes to the high byte when `cpu_hi`=1 and to the low byte when `cpu_hi`=0. A register's bank value is high<<8 | low, and the change is visible at the outputs after that clock edge.
- R3: With `gran_sel`=0 (8 KB), all eight slots take their value from register 0.
- R4: With `gran_sel`=2 (2 KB), slot s uses register 2*(s/2). With `gran_sel`=3 (1 KB), slot s uses register s.
- R5: With `gran_sel`=1 (4 KB), slots 0-3 use register 2 if latch 0 is set and register 0 if it is clear. Slots 4-7 use register 6 if latch 1 is set and register 4 if it is clear.
- R6: A read (`ppu_rd`=1) triggers a latch when address bit 13 is 0 and bits [11:8] are 0xF. The triggered latch is the one for half h = address bit 12. Address bits [7:4] = 0xD clear that latch, and 0xE set it. The new selection appears at the outputs from the clock edge that ends the read, and not during the read.
- R7: The latches do not change for any read that misses the R6 condition. This covers bit 13 set, bits [11:8] not 0xF, or bits [7:4] other than 0xD/0xE. They also do not change in any cycle without `ppu_rd`.
- R8: While `latch_en`=0, both latches are held clear from the next clock edge on, whatever reads occur. The 4 KB halves then use registers 0 and 4.
- R9: Every slot output equals (register value AND `size_mask`) OR `outer_bank`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Bank byte write strobe |
| cpu_hi | input | 1 | 1 = high-byte window, 0 = low-byte window |
| cpu_idx | input | 3 | Register index of the write |
| cpu_data | input | 8 | Byte written |
| ppu_rd | input | 1 | Video-side read strobe |
| ppu_addr | input | 14 | Video-side read address |
| latch_en | input | 1 | Enables fetch-triggered latch switching |
| gran_sel | input | 2 | 0 = 8 KB, 1 = 4 KB, 2 = 2 KB, 3 = 1 KB |
| size_mask | input | 16 | AND mask applied to each bank value |
| outer_bank | input | 16 | Bits ORed into each bank value |
| slot_bank | output | 128 | Bank for slot s at bits [16*s+15:16*s] |

## Verification
The assertions check on every cycle the latch-update rules: a qualifying read sets or clears the addressed half's latch on the next edge, any other cycle leaves both latches alone, and a disabled feature forces them clear. They also check that 8 KB mode drives one value everywhere and that the outer bits always appear in the outputs. How registers map to slots under each granularity, the byte assembly of written values, the reset contents, and the fact that a latch change is not visible during the read itself can be shown only by the bench's scenarios. The bench compares every slot against a model of the register file and latches.

// File: rtl/chr_latch_pkg.sv
package chr_latch_pkg;
    typedef enum logic [1:0] {
        GRAN_8K = 2'd0,
        GRAN_4K = 2'd1,
        GRAN_2K = 2'd2,
        GRAN_1K = 2'd3
    } gran_e;

    // tile row nibbles that move a latch
    localparam logic [3:0] NIB_CLEAR = 4'hD;
    localparam logic [3:0] NIB_SET   = 4'hE;
    localparam logic [3:0] ROW_HIT   = 4'hF;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs #(
    parameter int NREG = 8,
    parameter int BW   = 8,
    localparam int IW  = $clog2(NREG),
    localparam int VW  = 2 * BW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic                     hi,
    input  logic [IW-1:0]            idx,
    input  logic [BW-1:0]            data,
    output logic [NREG-1:0][VW-1:0]  val
);
    typedef struct packed {
        logic [NREG-1:0][BW-1:0] hi_b;
        logic [NREG-1:0][BW-1:0] lo_b;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            if (hi) st_d.hi_b[idx] = data;
            else    st_d.lo_b[idx] = data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

    for (genvar r = 0; r < NREG; r++) begin : g_val
        assign val[r] = {st_q.hi_b[r], st_q.lo_b[r]};
    end
endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
    import chr_latch_pkg::*;
#(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic [1:0]    alt
);
    typedef struct packed {
        logic [1:0] alt;
    } lat_t;

    lat_t st_d, st_q;
    logic row_hit;
    logic [3:0] nib;

    assign nib     = addr[7:4];
    assign row_hit = rd && (addr[AW-1:13] == '0) && (addr[11:8] == ROW_HIT);

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.alt = '0;
        end else if (row_hit && (nib == NIB_CLEAR || nib == NIB_SET)) begin
            st_d.alt[addr[12]] = (nib == NIB_SET);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alt = st_q.alt;
endmodule

// File: rtl/chr_slot_map.sv
module chr_slot_map
    import chr_latch_pkg::*;
#(
    parameter int NREG = 8,
    parameter int VW   = 16,
    localparam int IW  = $clog2(NREG),
    localparam int HALF = NREG / 2,
    localparam int PAIR_OFS = NREG / 4
) (
    input  gran_e                    gran,
    input  logic [NREG-1:0][VW-1:0]  val,
    input  logic [1:0]               alt,
    input  logic [VW-1:0]            mask,
    input  logic [VW-1:0]            outer,
    output logic [NREG-1:0][VW-1:0]  slot
);
    for (genvar s = 0; s < NREG; s++) begin : g_slot
        localparam int HB   = s / HALF;
        localparam int BASE = HB * HALF;
        logic [IW-1:0] idx;

        always_comb begin
            unique case (gran)
                GRAN_8K: idx = '0;
                GRAN_4K: idx = alt[HB] ? IW'(BASE + PAIR_OFS) : IW'(BASE);
                GRAN_2K: idx = IW'(s - (s % 2));
                default: idx = IW'(s);
            endcase
        end

        assign slot[s] = (val[idx] & mask) | outer;
    end
endmodule

// File: rtl/chr_latch_bank.sv
module chr_latch_bank
    import chr_latch_pkg::*;
#(
    parameter int NREG = 8,
    parameter int BW   = 8,
    parameter int AW   = 14,
    localparam int IW  = $clog2(NREG),
    localparam int VW  = 2 * BW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_wr,
    input  logic               cpu_hi,
    input  logic [IW-1:0]      cpu_idx,
    input  logic [BW-1:0]      cpu_data,
    input  logic               ppu_rd,
    input  logic [AW-1:0]      ppu_addr,
    input  logic               latch_en,
    input  logic [1:0]         gran_sel,
    input  logic [VW-1:0]      size_mask,
    input  logic [VW-1:0]      outer_bank,
    output logic [NREG*VW-1:0] slot_bank
);
    logic [NREG-1:0][VW-1:0] reg_val;
    logic [NREG-1:0][VW-1:0] slot_val;
    logic [1:0]              lat_alt;

    chr_bank_regs #(.NREG(NREG), .BW(BW)) i_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (cpu_wr),
        .hi   (cpu_hi),
        .idx  (cpu_idx),
        .data (cpu_data),
        .val  (reg_val)
    );

    chr_fetch_latch #(.AW(AW)) i_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (latch_en),
        .rd   (ppu_rd),
        .addr (ppu_addr),
        .alt  (lat_alt)
    );

    chr_slot_map #(.NREG(NREG), .VW(VW)) i_map (
        .gran (gran_e'(gran_sel)),
        .val  (reg_val),
        .alt  (lat_alt),
        .mask (size_mask),
        .outer(outer_bank),
        .slot (slot_val)
    );

    assign slot_bank = slot_val;
endmodule

// File: rtl/chr_latch_chk.sv
module chr_latch_chk #(
    parameter int NREG = 8,
    parameter int VW   = 16,
    parameter int AW   = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ppu_rd,
    input logic [AW-1:0]      ppu_addr,
    input logic               latch_en,
    input logic [1:0]         gran_sel,
    input logic [VW-1:0]      outer_bank,
    input logic [NREG*VW-1:0] slot_bank,
    input logic [1:0]         lat_alt
);
    logic row_ok, trig;
    assign row_ok = ppu_rd && (ppu_addr[AW-1:13] == '0) && (ppu_addr[11:8] == 4'hF);
    assign trig   = row_ok && (ppu_addr[7:4] == 4'hD || ppu_addr[7:4] == 4'hE);

    // R6
    lat_lo_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && trig && !ppu_addr[12]) |=> (lat_alt[0] == $past(ppu_addr[7:4] == 4'hE)));

    // R6
    lat_hi_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && trig && ppu_addr[12]) |=> (lat_alt[1] == $past(ppu_addr[7:4] == 4'hE)));

    // R7
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && !trig) |=> $stable(lat_alt));

    // R8
    lat_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (lat_alt == 2'b00));

    // R3
    one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gran_sel == 2'd0) |-> (slot_bank[VW-1:0] == slot_bank[NREG*VW-1 -: VW]));

    // R9
    outer_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_bank[VW-1:0] & outer_bank) == outer_bank));
endmodule

bind chr_latch_bank chr_latch_chk #(.NREG(NREG), .VW(VW), .AW(AW)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ppu_rd    (ppu_rd),
    .ppu_addr  (ppu_addr),
    .latch_en  (latch_en),
    .gran_sel  (gran_sel),
    .outer_bank(outer_bank),
    .slot_bank (slot_bank),
    .lat_alt   (lat_alt)
);

// File: tb/test_chr_latch_bank.sv
`timescale 1ns/1ps
module test_chr_latch_bank;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         cpu_wr = 0, cpu_hi = 0;
    logic [2:0]   cpu_idx = 0;
    logic [7:0]   cpu_data = 0;
    logic         ppu_rd = 0;
    logic [13:0]  ppu_addr = 0;
    logic         latch_en = 1;
    logic [1:0]   gran_sel = 3;
    logic [15:0]  size_mask = 16'hFFFF, outer_bank = 0;
    logic [127:0] slot_bank;

    int total = 0, bad = 0;
    logic [7:0] m_lo[8], m_hi[8];
    logic       m_lat[2];

    always #2.5 clk = ~clk;

    chr_latch_bank i_chr_latch_bank (.*);

    function automatic logic [15:0] exp_slot(int s);
        int r;
        case (gran_sel)
            2'd0: r = 0;
            2'd1: r = (s < 4) ? (m_lat[0] ? 2 : 0) : (m_lat[1] ? 6 : 4);
            2'd2: r = s - (s % 2);
            default: r = s;
        endcase
        return ({m_hi[r], m_lo[r]} & size_mask) | outer_bank;
    endfunction

    task automatic check_all(string req);
        for (int s = 0; s < 8; s++) begin
            logic [15:0] act, exp;
            act = slot_bank[16*s +: 16];
            exp = exp_slot(s);
            total++;
            if (act !== exp) begin
                bad++;
                $display("FAIL %s slot %0d actual=%h expected=%h", req, s, act, exp);
            end
        end
    endtask

    // one clock with the currently driven inputs, model follows, ends at negedge
    task automatic step();
        @(posedge clk);
        if (rst_n) begin
            if (cpu_wr) begin
                if (cpu_hi) m_hi[cpu_idx] = cpu_data;
                else        m_lo[cpu_idx] = cpu_data;
            end
            if (!latch_en) begin
                m_lat[0] = 0; m_lat[1] = 0;
            end else if (ppu_rd && !ppu_addr[13] && ppu_addr[11:8] == 4'hF &&
                         (ppu_addr[7:4] == 4'hD || ppu_addr[7:4] == 4'hE)) begin
                m_lat[ppu_addr[12]] = (ppu_addr[7:4] == 4'hE);
            end
        end
        @(negedge clk);
        cpu_wr = 0; ppu_rd = 0;
    endtask

    task automatic wr_byte(logic hi, int idx, logic [7:0] d);
        cpu_wr = 1; cpu_hi = hi; cpu_idx = 3'(idx); cpu_data = d;
        step();
    endtask

    task automatic rd_addr(logic [13:0] a);
        ppu_rd = 1; ppu_addr = a;
        step();
    endtask

    initial begin
        #(5.0 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 8; i++) begin m_lo[i] = 8'hFF; m_hi[i] = 8'hFF; end
        m_lat[0] = 0; m_lat[1] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");
        gran_sel = 1; #1 check_all("R1");

        // R2: distinct values in every byte
        for (int i = 0; i < 8; i++) begin
            wr_byte(0, i, 8'(i * 17));
            wr_byte(1, i, 8'(8'h80 + i));
        end
        gran_sel = 3; #1 check_all("R2");
        gran_sel = 2; #1 check_all("R4");
        gran_sel = 0; #1 check_all("R3");

        // R5 / R6 directed latch flips
        gran_sel = 1;
        ppu_rd = 1; ppu_addr = 14'h0FE5; #1 check_all("R6 before edge");
        step(); check_all("R6 lower set");
        rd_addr(14'h1FE8); check_all("R6 upper set");
        rd_addr(14'h0FD0); check_all("R5 lower clear");
        rd_addr(14'h1FDF); check_all("R5 upper clear");
        rd_addr(14'h0FE0); rd_addr(14'h1FE0);

        // R7 misses
        rd_addr(14'h2FD0); check_all("R7 bit13");
        rd_addr(14'h0ED0); check_all("R7 row");
        rd_addr(14'h1FC0); check_all("R7 nibble");
        ppu_addr = 14'h0FD0; step(); check_all("R7 no strobe");

        // R8 disabled feature
        latch_en = 0; step(); check_all("R8 forced");
        rd_addr(14'h0FE0); check_all("R8 ignored");
        latch_en = 1; #1 check_all("R8 reenable");

        // R9 mask and outer bits
        size_mask = 16'h00FF; outer_bank = 16'h0300; #1 check_all("R9");
        gran_sel = 3; #1 check_all("R9 1k");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) begin
                cpu_wr = 1; cpu_hi = 1'($urandom); cpu_idx = 3'($urandom); cpu_data = 8'($urandom);
            end else if (op < 8) begin
                ppu_rd = 1;
                if ($urandom_range(0, 1) == 1)
                    ppu_addr = {1'b0, 1'($urandom), 4'hF, ($urandom_range(0, 1) == 1) ? 4'hE : 4'hD, 4'($urandom)};
                else
                    ppu_addr = 14'($urandom);
            end else if (op == 8) begin
                gran_sel = 2'($urandom);
                size_mask = ($urandom_range(0, 1) == 1) ? 16'hFFFF : 16'($urandom);
                outer_bank = 16'($urandom) & ~size_mask;
            end else begin
                latch_en = ($urandom_range(0, 3) != 0);
            end
            step();
            check_all("R6 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule